// File: doc/BRIEF.md
# Byte-Lane Steering Bus Master

This block turns simple memory requests into bus cycles on a 16-bit multiplexed address/data bus that addresses bytes. A requester presents a 20-bit byte address, a size flag (byte or word), a direction and write data for one clock while the block is idle. The block then runs one or two bus cycles. Each cycle has a fixed sequence of states, and the block drives the address-latch strobe, the high-byte-lane enable, the memory/IO qualifier, the transfer direction, the read, write and data-enable strobes, and the shared address/data lines.

Memory sits in two byte-wide banks. The low lane (bits 7:0) serves even addresses and the high lane (bits 15:8) serves odd addresses. An aligned word moves in one cycle on both lanes. A word at an odd address is split into two byte cycles: the low byte goes at the odd address on the high lane, then the high byte goes at the next address on the low lane. For reads the two bytes are merged into one 16-bit result. A ready input stretches any cycle with wait states.

The controller has six states. IDLE moves to T1 on an accepted request. T1 always moves to T2 and T2 always moves to T3. T3 moves to T4 when ready is high, otherwise to TW. TW stays in TW while ready is low and moves to T4 when ready is high. T4 moves to T1 when the second half of a split word is still due, otherwise to IDLE.

Top module: `byte_lane_bus_master`

## Requirements
- R1: While reset is held, and in IDLE after it, ale=0, ad_oe=0, ad_out=0, addr_hi=0, bhe_n=1, mem_io=0, dt_r=0, rd_n=1, wr_n=1, den_n=1, busy=0, done=0 and rd_data=0.
- R2: A request with req_valid=1 is taken only in IDLE. busy is 1 from the first T1 through the final T4 and 0 otherwise. A request presented while busy=1 is dropped and starts no cycle.
- R3: In T1 alone, ale is 1 for exactly one clock, ad_out carries address bits 15:0 with ad_oe=1, and addr_hi carries address bits 19:16. addr_hi and bhe_n keep their values through T4.
- R4: Lane encoding, where A0 is ad_out[0] in T1: an even byte gives A0=0 and bhe_n=1, an odd byte gives A0=1 and bhe_n=0, and an even word gives A0=0 and bhe_n=0. The pair A0=1 with bhe_n=1 never occurs.
- R5: In a read, mem_io=0 and dt_r=0 in T1. From T2 to T4 mem_io=1 and dt_r=0. rd_n and den_n are 0 in T2, T3 and every TW, and 1 in T4. ad_oe is 0 from T2 onward.
- R6: In a write, mem_io=1 and dt_r=1 from T1 to T4. wr_n and den_n are 0 in T2, T3 and every TW, and 1 in T4. ad_oe=1, and ad_out holds the steered data unchanged from T2 through T4.
- R7: ready is sampled on the edge that ends T3 and on the edge that ends each TW. Every low sample adds one TW, so a cycle lasts 4 plus the number of low samples.
- R8: A word at an odd address A runs two back-to-back cycles. The first is at A with A0=1 and bhe_n=0. The second starts in the clock after the first T4, at (A+1) modulo 2^20, with A0=0 and bhe_n=1.
- R9: Write data steering: an even word drives wdata on both lanes, and a byte access drives wdata[7:0] on both lanes. For a split word, the first cycle drives wdata[7:0] on both lanes and the second drives wdata[15:8] on both lanes.
- R10: Read data is taken from bus_ad_in on the edge that ends the last T3 or TW. An even byte returns {8'h00, bits 7:0} and an odd byte returns {8'h00, bits 15:8}. An even word returns all 16 bits. A split word returns {second cycle bits 7:0, first cycle bits 15:8}.
- R11: done is 1 for exactly one clock, in the T4 of the last cycle of an access. rd_data is valid in that clock and holds until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (a byte uses bits 7:0) |
| busy | output | 1 | An access is in progress |
| done | output | 1 | Access finished (one clock) |
| rd_data | output | 16 | Assembled read result |
| ready | input | 1 | Memory ready; low adds wait states |
| bus_ad_in | input | 16 | Data read from the shared lines |
| ad_out | output | 16 | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Drive enable for ad_out |
| addr_hi | output | 4 | Address bits 19:16 |
| ale | output | 1 | Address latch strobe |
| bhe_n | output | 1 | High lane enable, active low |
| mem_io | output | 1 | 1 = memory transfer |
| dt_r | output | 1 | 1 = transmit (write), 0 = receive |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data enable, active low |

## Verification
A wrong state in the controller shows up at the strobes within one clock. A skipped or extra state makes rd_n, wr_n or den_n rise one clock early or late compared with the count of low ready samples. A lost second-half flag makes done come in the first T4 of a split word, or makes no second ale pulse follow it. A stale half or request register is seen in the next T1 as the wrong address, A0 or bhe_n, and in T4 of the final cycle as a wrongly assembled rd_data. A stuck IDLE exit is seen as busy or ale rising without a request.

// File: rtl/blm_pkg.sv
package blm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } bus_state_e;

endpackage

// File: rtl/blm_cycle_fsm.sv
module blm_cycle_fsm
    import blm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ready,
    input  logic       more,
    output bus_state_e state
);

    bus_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_T1;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_T3;
            ST_T3:   state_nx = ready ? ST_T4 : ST_TW;
            ST_TW:   state_nx = ready ? ST_T4 : ST_TW;
            ST_T4:   state_nx = more ? ST_T1 : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/blm_lane_steer.sv
module blm_lane_steer #(
    parameter int DATA_W = 16
) (
    input  logic              addr_lsb,
    input  logic              whole_word,
    input  logic              half_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic              bhe_n,
    output logic [DATA_W-1:0] wlanes
);

    localparam int LANE_W = DATA_W / 2;
    localparam int NLANES = DATA_W / LANE_W;

    logic [LANE_W-1:0] sel_byte;
    logic [DATA_W-1:0] dup_bytes;

    assign sel_byte = half_hi ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];

    for (genvar g = 0; g < NLANES; g++) begin : g_dup
        assign dup_bytes[g*LANE_W +: LANE_W] = sel_byte;
    end

    always_comb begin
        if (whole_word) begin
            bhe_n  = 1'b0;
            wlanes = wdata;
        end else begin
            bhe_n  = ~addr_lsb;
            wlanes = dup_bytes;
        end
    end

endmodule

// File: rtl/blm_read_merge.sv
module blm_read_merge #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              whole_word,
    input  logic              split,
    input  logic              half_hi,
    input  logic              odd_lane,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] result
);

    localparam int LANE_W = DATA_W / 2;

    logic [LANE_W-1:0] lane_byte;

    assign lane_byte = odd_lane ? bus_in[DATA_W-1:LANE_W] : bus_in[LANE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (capture) begin
            if (whole_word)
                result <= bus_in;
            else if (split && !half_hi)
                result[LANE_W-1:0] <= lane_byte;
            else if (split)
                result[DATA_W-1:LANE_W] <= lane_byte;
            else
                result <= {{LANE_W{1'b0}}, lane_byte};
        end
    end

endmodule

// File: rtl/byte_lane_bus_master.sv
module byte_lane_bus_master
    import blm_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_word,
    input  logic                   req_write,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   busy,
    output logic                   done,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   ready,
    input  logic [DATA_W-1:0]      bus_ad_in,
    output logic [DATA_W-1:0]      ad_out,
    output logic                   ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                   ale,
    output logic                   bhe_n,
    output logic                   mem_io,
    output logic                   dt_r,
    output logic                   rd_n,
    output logic                   wr_n,
    output logic                   den_n
);

    localparam int HI_W = ADDR_W - DATA_W;

    bus_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic              word_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic              half_q;
    logic              split_q;
    logic              whole_q;
    logic              more;
    logic              start;
    logic              capture;
    logic [ADDR_W-1:0] cycle_addr;
    logic              lane_bhe_n;
    logic [DATA_W-1:0] wlanes;

    assign start      = (state == ST_IDLE) && req_valid;
    assign split_q    = word_q && addr_q[0];
    assign whole_q    = word_q && !addr_q[0];
    assign more       = split_q && !half_q;
    assign cycle_addr = half_q ? addr_q + ADDR_W'(1) : addr_q;
    assign capture    = ((state == ST_T3) || (state == ST_TW)) && ready && !write_q;
    assign busy       = (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            word_q  <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
            half_q  <= 1'b0;
        end else if (start) begin
            addr_q  <= req_addr;
            word_q  <= req_word;
            write_q <= req_write;
            wdata_q <= req_wdata;
            half_q  <= 1'b0;
        end else if (state == ST_T4 && more) begin
            half_q  <= 1'b1;
        end
    end

    blm_cycle_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ready (ready),
        .more  (more),
        .state (state)
    );

    blm_lane_steer #(.DATA_W(DATA_W)) u_steer (
        .addr_lsb   (cycle_addr[0]),
        .whole_word (whole_q),
        .half_hi    (half_q),
        .wdata      (wdata_q),
        .bhe_n      (lane_bhe_n),
        .wlanes     (wlanes)
    );

    blm_read_merge #(.DATA_W(DATA_W)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .whole_word (whole_q),
        .split      (split_q),
        .half_hi    (half_q),
        .odd_lane   (cycle_addr[0]),
        .bus_in     (bus_ad_in),
        .result     (rd_data)
    );

    always_comb begin
        ale     = 1'b0;
        ad_out  = '0;
        ad_oe   = 1'b0;
        addr_hi = '0;
        bhe_n   = 1'b1;
        mem_io  = 1'b0;
        dt_r    = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        den_n   = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_T1: begin
                ale     = 1'b1;
                ad_oe   = 1'b1;
                ad_out  = cycle_addr[DATA_W-1:0];
                addr_hi = cycle_addr[ADDR_W-1:ADDR_W-HI_W];
                bhe_n   = lane_bhe_n;
                mem_io  = write_q;
                dt_r    = write_q;
            end
            ST_T2, ST_T3, ST_TW: begin
                addr_hi = cycle_addr[ADDR_W-1:ADDR_W-HI_W];
                bhe_n   = lane_bhe_n;
                mem_io  = 1'b1;
                dt_r    = write_q;
                den_n   = 1'b0;
                if (write_q) begin
                    wr_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = wlanes;
                end else begin
                    rd_n   = 1'b0;
                end
            end
            ST_T4: begin
                addr_hi = cycle_addr[ADDR_W-1:ADDR_W-HI_W];
                bhe_n   = lane_bhe_n;
                mem_io  = 1'b1;
                dt_r    = write_q;
                done    = !more;
                if (write_q) begin
                    ad_oe  = 1'b1;
                    ad_out = wlanes;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/blm_checker.sv
module blm_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic              bhe_n,
    input logic              mem_io,
    input logic              dt_r,
    input logic              rd_n,
    input logic              wr_n,
    input logic              den_n,
    input logic              busy,
    input logic              done,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out
);

    a_r2_ale_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> busy);

    a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r4_lane_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !(ad_out[0] && bhe_n));

    a_r5_rd_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(ale));

    a_r5_rd_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (wr_n && !dt_r && mem_io && !den_n && !ad_oe));

    a_r6_wr_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (rd_n && ad_oe && dt_r && mem_io && !den_n));

    a_r6_wr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> $stable(ad_out));

    a_r11_done_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && rd_n && wr_n && !ale));

endmodule

bind byte_lane_bus_master blm_checker #(.DATA_W(DATA_W)) u_blm_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .bhe_n  (bhe_n),
    .mem_io (mem_io),
    .dt_r   (dt_r),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .den_n  (den_n),
    .busy   (busy),
    .done   (done),
    .ad_oe  (ad_oe),
    .ad_out (ad_out)
);

// File: tb/byte_lane_bus_master_test.sv
module byte_lane_bus_master_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rd_data;
    logic        ready = 1'b1;
    logic [15:0] bus_ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  addr_hi;
    logic        ale, bhe_n, mem_io, dt_r, rd_n, wr_n, den_n;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_lane_bus_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .ready(ready),
        .bus_ad_in(bus_ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
        .ale(ale), .bhe_n(bhe_n), .mem_io(mem_io), .dt_r(dt_r),
        .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Runs one full access and checks every clock of every bus cycle.
    task automatic do_access(input logic [19:0] addr, input bit word, input bit write,
                             input logic [15:0] wdata, input int waits,
                             input logic [15:0] bus0, input logic [15:0] bus1,
                             input bit poke);
        bit split, whole;
        int nh;
        logic [19:0] haddr;
        logic ea0, ebhe;
        logic [15:0] ewl, erd;
        logic [7:0] b;
        split = word && addr[0];
        whole = word && !addr[0];
        nh = split ? 2 : 1;
        if (whole)      erd = bus0;
        else if (split) erd = {bus1[7:0], bus0[15:8]};
        else            erd = addr[0] ? {8'h00, bus0[15:8]} : {8'h00, bus0[7:0]};
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_word = word;
        req_write = write; req_wdata = wdata;
        for (int h = 0; h < nh; h++) begin
            haddr = (h == 1) ? addr + 20'd1 : addr;
            ea0   = whole ? 1'b0 : haddr[0];
            ebhe  = whole ? 1'b0 : ~haddr[0];
            b     = (h == 1) ? wdata[15:8] : wdata[7:0];
            ewl   = whole ? wdata : {b, b};
            // T1
            @(negedge clk);
            req_valid = 1'b0;
            check(ale && busy && ad_oe, "R3 R2 T1 ale/busy", {ale, busy, ad_oe}, 3'b111);
            check(ad_out == haddr[15:0] && addr_hi == haddr[19:16], "R3 R8 T1 address",
                  {addr_hi, ad_out}, haddr);
            check(ad_out[0] == ea0 && bhe_n == ebhe, "R4 lane select",
                  {ad_out[0], bhe_n}, {ea0, ebhe});
            check(mem_io == write && dt_r == write && rd_n && wr_n && den_n,
                  "R5 R6 T1 control", {mem_io, dt_r, rd_n, wr_n, den_n},
                  {write, write, 3'b111});
            // T2
            @(negedge clk);
            bus_ad_in = (h == 1) ? bus1 : bus0;
            if (poke) begin
                req_valid = 1'b1; req_addr = 20'h5A5A4; req_word = 1'b1;
            end
            check(!ale && mem_io && dt_r == write && bhe_n == ebhe && addr_hi == haddr[19:16],
                  "R5 R6 R3 T2 control", {ale, mem_io, dt_r, bhe_n}, {1'b0, 1'b1, write, ebhe});
            if (write)
                check(!wr_n && rd_n && !den_n && ad_oe && ad_out == ewl,
                      "R6 R9 T2 write data", {wr_n, rd_n, den_n, ad_oe, ad_out},
                      {4'b0101, ewl});
            else
                check(!rd_n && wr_n && !den_n && !ad_oe, "R5 T2 read strobes",
                      {rd_n, wr_n, den_n, ad_oe}, 4'b0100);
            // T3
            @(negedge clk);
            req_valid = 1'b0;
            ready = (waits == 0);
            check(write ? (!wr_n && !den_n && ad_out == ewl) : (!rd_n && !den_n),
                  "R7 T3 strobes held", {rd_n, wr_n, den_n}, {write, !write, 1'b0});
            for (int i = 0; i < waits; i++) begin
                @(negedge clk);
                ready = (i == waits - 1);
                check(write ? (!wr_n && !den_n && ad_out == ewl) : (!rd_n && !den_n),
                      "R7 wait strobes held", {rd_n, wr_n, den_n}, {write, !write, 1'b0});
            end
            // T4
            @(negedge clk);
            ready = 1'b1;
            check(rd_n && wr_n && den_n && busy, "R7 R5 R6 T4 release",
                  {rd_n, wr_n, den_n, busy}, 4'b1111);
            if (write)
                check(ad_oe && ad_out == ewl, "R6 R9 T4 data hold", {ad_oe, ad_out}, {1'b1, ewl});
            check(done == (h == nh - 1), "R11 done timing", done, (h == nh - 1));
            if (h == nh - 1 && !write)
                check(rd_data == erd, "R10 read assembly", rd_data, erd);
        end
        @(negedge clk);
        check(!busy && !ale && !done && rd_n && wr_n, "R2 R11 idle after access",
              {busy, ale, done}, 3'b000);
        if (!write)
            check(rd_data == erd, "R11 rd_data held", rd_data, erd);
        if (poke) begin
            @(negedge clk);
            check(!busy && !ale, "R2 request while busy ignored", {busy, ale}, 2'b00);
        end
    endtask

    task automatic test_reset();
        check(!ale && !ad_oe && ad_out == 0 && addr_hi == 0 && bhe_n && !mem_io && !dt_r,
              "R1 reset bus idle", {ale, ad_oe, bhe_n, mem_io, dt_r}, 5'b00100);
        check(rd_n && wr_n && den_n && !busy && !done && rd_data == 0,
              "R1 reset strobes", {rd_n, wr_n, den_n, busy, done}, 5'b11100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // even byte read
        do_access(20'h01234, 1'b0, 1'b0, 16'h0000, 0, 16'hBEEF, 16'h0000, 1'b0);
        // odd byte read with one wait
        do_access(20'h31235, 1'b0, 1'b0, 16'h0000, 1, 16'hC3A7, 16'h0000, 1'b0);
        // even word read
        do_access(20'h02002, 1'b1, 1'b0, 16'h0000, 0, 16'h9182, 16'h0000, 1'b0);
        // even word write, two waits, request poked while busy
        do_access(20'hA0010, 1'b1, 1'b1, 16'h5E6F, 2, 16'h0000, 16'h0000, 1'b1);
        // odd byte write
        do_access(20'h00777, 1'b0, 1'b1, 16'h11D4, 0, 16'h0000, 16'h0000, 1'b0);
        // split word read across a boundary, one wait
        do_access(20'h01FFF, 1'b1, 1'b0, 16'h0000, 1, 16'h34AB, 16'hCD56, 1'b0);
        // split word write
        do_access(20'h4F0F1, 1'b1, 1'b1, 16'h8A3C, 0, 16'h0000, 16'h0000, 1'b0);
        // split word read at top of space, wraps to zero
        do_access(20'hFFFFF, 1'b1, 1'b0, 16'h0000, 3, 16'h7700, 16'h0099, 1'b0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule